// File: doc/BRIEF.md
# Nine-Bit Serial Transceiver with Address Filter

The block is a full-duplex asynchronous serial transceiver that moves nine-bit characters. An external strobe, `tick_i`, runs at sixteen times the bit rate. Each frame is a low start bit, eight data bits sent least significant first, a ninth bit, and then one or two high stop bits. A single-entry holding register sits in front of the transmit shifter. A receive shifter fills a single-entry receive buffer. Status outputs report that the holding register is empty, that the receive buffer is full, and that a framing error was seen.

For multi-drop links the receiver has an attention state. While it is set, every character whose ninth bit is zero is dropped. The first character whose ninth bit is one is an address: it is stored, and attention clears by itself. From then on all characters are stored until software sets attention again.

Two further controls support test and power management. A loopback control routes the transmit serial stream back into the receiver for self-test. A reinitialise pulse puts the serial engines back to a quiet state without losing the buffered data.

Top module: `attn_uart9`

## Requirements
- R1: After reset: `tx_o` is 1, `tx_empty_o` is 1, `rx_full_o` is 0, `frame_err_o` is 0 and `attn_o` is 0.
- R2: A transmitted frame is one 0 start bit, then `tx_data_i` bits 0 to 7, then the `tx_bit9_i` value captured at the write, then a 1 stop bit. A second 1 stop bit follows when `two_stop_i` is 1. Each bit lasts 16 ticks, and an idle `tx_o` is 1.
- R3: `tx_empty_o` is 0 in the cycle after a `tx_wr_i` pulse. It returns to 1 on the first tick that finds the shifter idle, which is when the character moves into the shifter.
- R4: The receiver samples each bit at its middle, 8 ticks after the start edge and then every 16 ticks. Line disturbances near the bit edges do not change the data. A start bit that is high again at mid-bit is rejected and stores nothing.
- R5: A received character is stored in `rx_data_o`, with its ninth bit in `rx_bit9_o`, and `rx_full_o` is set. A `rx_rd_i` pulse clears `rx_full_o`.
- R6: A stop bit sampled as 0 sets `frame_err_o`, and the character is still stored. The flag stays set across later good characters until an `err_clr_i` pulse clears it.
- R7: While `attn_o` is 1, a character whose ninth bit is 0 is discarded. `rx_full_o`, `rx_data_o`, `rx_bit9_o` and `frame_err_o` all keep their values.
- R8: While `attn_o` is 1, a character whose ninth bit is 1 is stored and sets `rx_full_o`, and `attn_o` clears. After that, characters with a ninth bit of 0 are stored again.
- R9: With `loopback_i` at 1, the receiver takes its input from the transmit serial stream and `rx_i` is ignored.
- R10: In the cycle after a `reinit_i` pulse: `tx_o` is 1, `tx_empty_o` is 1, and `rx_full_o` and `frame_err_o` are 0. A frame in flight is abandoned and the held transmit character is not sent. `rx_data_o`, `rx_bit9_o` and `attn_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample strobe, 16 per bit |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| tx_wr_i | input | 1 | Write pulse for the transmit holding register |
| tx_data_i | input | 8 | Transmit data byte |
| tx_bit9_i | input | 1 | Ninth bit to send, captured with the write |
| two_stop_i | input | 1 | 1: send two stop bits |
| loopback_i | input | 1 | 1: receiver listens to the transmitter |
| rx_rd_i | input | 1 | Read pulse, clears receive-full |
| err_clr_i | input | 1 | Clears the framing error |
| attn_set_i | input | 1 | Sets the attention state |
| reinit_i | input | 1 | Low-power reinitialise pulse |
| rx_data_o | output | 8 | Received data byte |
| rx_bit9_o | output | 1 | Received ninth bit |
| rx_full_o | output | 1 | Receive buffer holds an unread character |
| tx_empty_o | output | 1 | Transmit holding register is free |
| frame_err_o | output | 1 | Sticky framing error |
| attn_o | output | 1 | Attention state, dropping data characters |

## Verification
Most internal faults in this block appear at the ports within one frame time. A receive bit counter or sample point that is off by one shifts or corrupts `rx_data_o` on the next character. A wrong attention decision shows up as `rx_full_o` rising, or failing to rise, at the stop-bit sample. A transmit shifter fault distorts the captured frame on `tx_o` in the first bit period where it matters. Reinitialise faults are visible in the cycle after the pulse, or as a stray start bit in the hundreds of cycles that follow.

// File: rtl/attn_uart9_pkg.sv
package attn_uart9_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/attn_uart9_tx.sv
module attn_uart9_tx #(
  parameter int OSR = 16,
  parameter int FW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reinit_i,
  input  logic          two_stop_i,
  input  logic          wr_i,
  input  logic [FW-1:0] wr_data_i,
  output logic          empty_o,
  output logic          tx_o
);
  localparam int CW  = $clog2(OSR);
  localparam int SW  = FW + 3;
  localparam int BCW = $clog2(SW + 1);

  logic [FW-1:0]  buf_q;
  logic           empty_q;
  logic [SW-1:0]  sr_q;
  logic [BCW-1:0] bits_q;
  logic [CW-1:0]  cnt_q;
  logic           busy, load;

  assign busy = (bits_q != '0);
  assign load = tick_i && !busy && !empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      empty_q <= 1'b1;
      sr_q    <= '1;
      bits_q  <= '0;
      cnt_q   <= '0;
    end else if (reinit_i) begin
      empty_q <= 1'b1;
      sr_q    <= '1;
      bits_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (load) begin
        sr_q    <= {2'b11, buf_q, 1'b0};
        bits_q  <= two_stop_i ? BCW'(SW) : BCW'(SW - 1);
        cnt_q   <= '0;
        empty_q <= 1'b1;
      end else if (busy && tick_i) begin
        if (cnt_q == CW'(OSR - 1)) begin
          sr_q   <= {1'b1, sr_q[SW-1:1]};
          bits_q <= bits_q - 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (wr_i) begin
        buf_q   <= wr_data_i;
        empty_q <= 1'b0;
      end
    end
  end

  assign empty_o = empty_q;
  assign tx_o    = sr_q[0];

  assert_idle_high_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> tx_o);
  assert_empty_drop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !reinit_i) |=> !empty_o);
  assert_reinit_tx_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (tx_o && empty_o));
endmodule

// File: rtl/attn_uart9_rx.sv
module attn_uart9_rx
  import attn_uart9_pkg::*;
#(
  parameter int OSR = 16,
  parameter int FW  = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reinit_i,
  input  logic          line_i,
  output logic          valid_o,
  output logic [FW-1:0] data_o,
  output logic          stop_ok_o
);
  localparam int CW  = $clog2(OSR);
  localparam int BNW = $clog2(FW);
  localparam int MID = OSR / 2 - 1;

  rx_state_e      state_q;
  logic [CW-1:0]  cnt_q;
  logic [BNW-1:0] bitn_q;
  logic [FW-1:0]  sh_q;
  logic           valid_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      bitn_q  <= '0;
      sh_q    <= '0;
      valid_q <= 1'b0;
      stop_q  <= 1'b1;
    end else begin
      valid_q <= 1'b0;
      if (reinit_i) begin
        state_q <= RX_IDLE;
        cnt_q   <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          RX_IDLE: if (!line_i) begin
            state_q <= RX_START;
            cnt_q   <= '0;
          end
          RX_START: begin
            if (cnt_q == CW'(MID)) begin
              cnt_q   <= '0;
              bitn_q  <= '0;
              state_q <= line_i ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q <= '0;
              sh_q  <= {line_i, sh_q[FW-1:1]};
              if (bitn_q == BNW'(FW - 1)) state_q <= RX_STOP;
              else bitn_q <= bitn_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == CW'(OSR - 1)) begin
              cnt_q   <= '0;
              valid_q <= 1'b1;
              stop_q  <= line_i;
              state_q <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end

  assign valid_o   = valid_q;
  assign data_o    = sh_q;
  assign stop_ok_o = stop_q;

  assert_false_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_START && tick_i && !reinit_i && cnt_q == CW'(MID) && line_i)
      |=> (state_q == RX_IDLE && !valid_o));
  assert_valid_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/attn_uart9_regs.sv
module attn_uart9_regs #(
  parameter int FW = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reinit_i,
  input  logic          char_valid_i,
  input  logic [FW-1:0] char_data_i,
  input  logic          char_stop_ok_i,
  input  logic          rd_i,
  input  logic          err_clr_i,
  input  logic          attn_set_i,
  output logic [FW-1:0] rx_buf_o,
  output logic          rx_full_o,
  output logic          frame_err_o,
  output logic          attn_o
);
  logic [FW-1:0] buf_q;
  logic          full_q, err_q, attn_q;
  logic          is_addr, accept;

  assign is_addr = char_data_i[FW-1];
  assign accept  = char_valid_i && !(attn_q && !is_addr);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      full_q <= 1'b0;
      err_q  <= 1'b0;
      attn_q <= 1'b0;
    end else begin
      if (attn_set_i) attn_q <= 1'b1;
      else if (!reinit_i && accept && is_addr) attn_q <= 1'b0;
      if (reinit_i) begin
        full_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        if (rd_i) full_q <= 1'b0;
        if (err_clr_i) err_q <= 1'b0;
        if (accept) begin
          buf_q  <= char_data_i;
          full_q <= 1'b1;
          if (!char_stop_ok_i) err_q <= 1'b1;
        end
      end
    end
  end

  assign rx_buf_o    = buf_q;
  assign rx_full_o   = full_q;
  assign frame_err_o = err_q;
  assign attn_o      = attn_q;

  assert_discard_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && attn_q && !is_addr && !reinit_i && !rd_i && !err_clr_i)
      |=> ($stable(rx_full_o) && $stable(rx_buf_o) && $stable(frame_err_o)));
  assert_addr_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_valid_i && attn_q && is_addr && !reinit_i && !attn_set_i)
      |=> (!attn_o && rx_full_o));
  assert_reinit_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reinit_i |=> (!rx_full_o && !frame_err_o && $stable(rx_buf_o)));
endmodule

// File: rtl/attn_uart9.sv
module attn_uart9 #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rx_i,
  output logic              tx_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_bit9_i,
  input  logic              two_stop_i,
  input  logic              loopback_i,
  input  logic              rx_rd_i,
  input  logic              err_clr_i,
  input  logic              attn_set_i,
  input  logic              reinit_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              rx_full_o,
  output logic              tx_empty_o,
  output logic              frame_err_o,
  output logic              attn_o
);
  localparam int FW = DATA_W + 1;

  logic          tx_line;
  logic [1:0]    sync_q;
  logic          ch_valid, ch_stop_ok;
  logic [FW-1:0] ch_data, rx_buf;

  attn_uart9_tx #(.OSR(OSR), .FW(FW)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .reinit_i   (reinit_i),
    .two_stop_i (two_stop_i),
    .wr_i       (tx_wr_i),
    .wr_data_i  ({tx_bit9_i, tx_data_i}),
    .empty_o    (tx_empty_o),
    .tx_o       (tx_line)
  );

  // receive line select, then two-stage synchroniser
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], loopback_i ? tx_line : rx_i};
  end

  attn_uart9_rx #(.OSR(OSR), .FW(FW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .reinit_i  (reinit_i),
    .line_i    (sync_q[1]),
    .valid_o   (ch_valid),
    .data_o    (ch_data),
    .stop_ok_o (ch_stop_ok)
  );

  attn_uart9_regs #(.FW(FW)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .reinit_i       (reinit_i),
    .char_valid_i   (ch_valid),
    .char_data_i    (ch_data),
    .char_stop_ok_i (ch_stop_ok),
    .rd_i           (rx_rd_i),
    .err_clr_i      (err_clr_i),
    .attn_set_i     (attn_set_i),
    .rx_buf_o       (rx_buf),
    .rx_full_o      (rx_full_o),
    .frame_err_o    (frame_err_o),
    .attn_o         (attn_o)
  );

  assign tx_o      = tx_line;
  assign rx_data_o = rx_buf[DATA_W-1:0];
  assign rx_bit9_o = rx_buf[FW-1];
endmodule

// File: tb/attn_uart9_tb_top.sv
module attn_uart9_tb_top;
  localparam int BITC = 32; // clocks per bit: 16 ticks, one tick per 2 clocks

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       rx_i = 1'b1;
  logic       tx_o;
  logic       tx_wr_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       tx_bit9_i = 1'b0;
  logic       two_stop_i = 1'b0;
  logic       loopback_i = 1'b0;
  logic       rx_rd_i = 1'b0;
  logic       err_clr_i = 1'b0;
  logic       attn_set_i = 1'b0;
  logic       reinit_i = 1'b0;
  logic [7:0] rx_data_o;
  logic       rx_bit9_o, rx_full_o, tx_empty_o, frame_err_o, attn_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  attn_uart9 dut_i (
    .clk_i, .rst_ni, .tick_i, .rx_i, .tx_o, .tx_wr_i, .tx_data_i, .tx_bit9_i,
    .two_stop_i, .loopback_i, .rx_rd_i, .err_clr_i, .attn_set_i, .reinit_i,
    .rx_data_o, .rx_bit9_o, .rx_full_o, .tx_empty_o, .frame_err_o, .attn_o
  );

  always #10 clk_i = ~clk_i;

  initial begin
    forever begin
      @(negedge clk_i) tick_i = 1'b1;
      @(negedge clk_i) tick_i = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk_i) sig = 1'b1;
    @(negedge clk_i) sig = 1'b0;
  endtask

  task automatic send_rx(input logic [8:0] d, input bit stop, input bit glitch);
    logic [10:0] fr;
    fr = {stop, d, 1'b0};
    for (int b = 0; b < 11; b++) begin
      for (int c = 0; c < BITC; c++) begin
        @(negedge clk_i);
        rx_i = (glitch && (c < 4 || c >= BITC - 4)) ? ~fr[b] : fr[b];
      end
    end
    @(negedge clk_i) rx_i = 1'b1;
    repeat (BITC) @(negedge clk_i);
  endtask

  task automatic write_tx(input logic [8:0] d);
    @(negedge clk_i);
    tx_wr_i = 1'b1; tx_data_i = d[7:0]; tx_bit9_i = d[8];
    @(negedge clk_i);
    tx_wr_i = 1'b0;
  endtask

  task automatic cap_tx(output logic [11:0] bits);
    int guard = 0;
    bits = '1;
    @(negedge clk_i);
    while (tx_o && guard < 2000) begin
      @(negedge clk_i);
      guard++;
    end
    repeat (BITC / 2) @(negedge clk_i);
    bits[0] = tx_o;
    for (int i = 1; i < 12; i++) begin
      repeat (BITC) @(negedge clk_i);
      bits[i] = tx_o;
    end
  endtask

  task automatic wait_full();
    int guard = 0;
    while (!rx_full_o && guard < 2000) begin
      @(negedge clk_i);
      guard++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    logic [8:0]  d, prev;
    logic [11:0] cap;
    int lows;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check(tx_o == 1'b1, "R1 tx_o", tx_o, 1);
    check(tx_empty_o == 1'b1, "R1 tx_empty", tx_empty_o, 1);
    check(rx_full_o == 1'b0, "R1 rx_full", rx_full_o, 0);
    check(frame_err_o == 1'b0, "R1 frame_err", frame_err_o, 0);
    check(attn_o == 1'b0, "R1 attn", attn_o, 0);

    // R5 receive sweep
    for (int k = 0; k < 20; k++) begin
      d = {k[0], 8'(k * 37 + 5)};
      send_rx(d, 1'b1, 1'b0);
      check(rx_full_o, "R5 full", rx_full_o, 1);
      check({rx_bit9_o, rx_data_o} == d, "R5 data", {rx_bit9_o, rx_data_o}, d);
      check(!frame_err_o, "R5 no err", frame_err_o, 0);
      pulse(rx_rd_i);
      check(!rx_full_o, "R5 read clears", rx_full_o, 0);
    end

    // R4 mid-bit sampling with edge disturbances
    for (int k = 0; k < 4; k++) begin
      d = {k[1], 8'(8'hA5 ^ 8'(k * 77))};
      send_rx(d, 1'b1, 1'b1);
      check({rx_bit9_o, rx_data_o} == d, "R4 edge glitch data", {rx_bit9_o, rx_data_o}, d);
      pulse(rx_rd_i);
    end
    // R4 short start pulse rejected
    @(negedge clk_i) rx_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rx_i = 1'b1;
    repeat (450) @(negedge clk_i);
    check(!rx_full_o, "R4 false start", rx_full_o, 0);
    send_rx(9'h0C3, 1'b1, 1'b0);
    check({rx_bit9_o, rx_data_o} == 9'h0C3, "R4 recovery", {rx_bit9_o, rx_data_o}, 9'h0C3);
    pulse(rx_rd_i);

    // R6 framing error
    send_rx(9'h12E, 1'b0, 1'b0);
    check(frame_err_o, "R6 err set", frame_err_o, 1);
    check({rx_bit9_o, rx_data_o} == 9'h12E, "R6 stored", {rx_bit9_o, rx_data_o}, 9'h12E);
    pulse(rx_rd_i);
    send_rx(9'h011, 1'b1, 1'b0);
    check(frame_err_o, "R6 sticky", frame_err_o, 1);
    pulse(err_clr_i);
    check(!frame_err_o, "R6 clear", frame_err_o, 0);
    pulse(rx_rd_i);

    // R7 / R8 attention
    prev = {rx_bit9_o, rx_data_o};
    pulse(attn_set_i);
    check(attn_o, "R7 attn set", attn_o, 1);
    send_rx(9'h055, 1'b1, 1'b0);
    check(!rx_full_o, "R7 data dropped", rx_full_o, 0);
    check({rx_bit9_o, rx_data_o} == prev, "R7 buffer kept", {rx_bit9_o, rx_data_o}, prev);
    send_rx(9'h066, 1'b0, 1'b0);
    check(!frame_err_o, "R7 no err on dropped", frame_err_o, 0);
    check(attn_o, "R7 attn held", attn_o, 1);
    send_rx(9'h1A3, 1'b1, 1'b0);
    check(rx_full_o, "R8 addr full", rx_full_o, 1);
    check({rx_bit9_o, rx_data_o} == 9'h1A3, "R8 addr data", {rx_bit9_o, rx_data_o}, 9'h1A3);
    check(!attn_o, "R8 attn cleared", attn_o, 0);
    pulse(rx_rd_i);
    send_rx(9'h03C, 1'b1, 1'b0);
    check(rx_full_o, "R8 data after addr", rx_full_o, 1);
    check({rx_bit9_o, rx_data_o} == 9'h03C, "R8 data value", {rx_bit9_o, rx_data_o}, 9'h03C);
    pulse(rx_rd_i);

    // R2 / R3 transmit frames, one and two stop bits
    for (int k = 0; k < 8; k++) begin
      d = {k[1], 8'(k * 53 + 9)};
      two_stop_i = k[0];
      fork
        cap_tx(cap);
        begin
          write_tx(d);
          check(!tx_empty_o, "R3 empty drop", tx_empty_o, 0);
          repeat (3) @(negedge clk_i);
          check(tx_empty_o, "R3 transfer", tx_empty_o, 1);
          write_tx(9'h000);
        end
      join
      check(cap[0] == 1'b0, "R2 start bit", cap[0], 0);
      check(cap[9:1] == d, "R2 data bits", cap[9:1], d);
      check(cap[10] == 1'b1, "R2 stop bit", cap[10], 1);
      check(cap[11] == k[0], "R2 second stop", cap[11], k[0]);
      repeat (16 * BITC) @(negedge clk_i);
      check(tx_o, "R2 idle high", tx_o, 1);
    end
    two_stop_i = 1'b0;

    // R9 loopback ignores rx_i
    @(negedge clk_i);
    loopback_i = 1'b1;
    rx_i = 1'b0;
    for (int k = 0; k < 6; k++) begin
      d = {~k[0], 8'(k * 91 + 3)};
      write_tx(d);
      wait_full();
      @(negedge clk_i);
      check(rx_full_o, "R9 loop full", rx_full_o, 1);
      check({rx_bit9_o, rx_data_o} == d, "R9 loop data", {rx_bit9_o, rx_data_o}, d);
      check(!frame_err_o, "R9 loop err", frame_err_o, 0);
      pulse(rx_rd_i);
    end
    repeat (4 * BITC) @(negedge clk_i);
    rx_i = 1'b1;
    loopback_i = 1'b0;
    repeat (BITC) @(negedge clk_i);

    // R10 reinitialise
    send_rx(9'h15A, 1'b0, 1'b0);
    pulse(attn_set_i);
    write_tx(9'h0F0);
    repeat (100) @(negedge clk_i);
    @(negedge clk_i) reinit_i = 1'b1;
    @(negedge clk_i) reinit_i = 1'b0;
    check(tx_o, "R10 tx high", tx_o, 1);
    check(tx_empty_o, "R10 tx empty", tx_empty_o, 1);
    check(!rx_full_o, "R10 rx_full cleared", rx_full_o, 0);
    check(!frame_err_o, "R10 err cleared", frame_err_o, 0);
    check({rx_bit9_o, rx_data_o} == 9'h15A, "R10 rx buffer kept", {rx_bit9_o, rx_data_o}, 9'h15A);
    check(attn_o, "R10 attn kept", attn_o, 1);
    lows = 0;
    for (int c = 0; c < 20 * BITC; c++) begin
      @(negedge clk_i);
      if (!tx_o) lows++;
    end
    check(lows == 0, "R10 no resend", lows, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule